// File: doc/BRIEF.md
# Queued SPI Slave Controller

This block is a SPI slave that works through a queue of sixteen 16-bit entries with no help from the CPU. Each entry holds a transmit word and a receive word. The CPU loads the transmit words, sets a start index and an end index, picks the clock polarity, the clock phase and the word length, and enables the block. The external master then clocks words in and out. After each complete word, the block stores what it received in the current entry, records that entry's index, moves to the next entry and preloads the next transmit word. SCK, MOSI and the active-low select pass through a two-stage synchroniser into the system clock domain, so the serial clock must be several system clocks slower than the system clock.

A four-state machine sequences the block:
- OFF: the enable bit is clear. It moves to ARMED when the enable bit is set.
- ARMED: enabled but not selected. It moves to XFER when select falls, loading the transmit word of the entry it starts at. It returns to OFF when the enable bit is cleared.
- XFER: shifting. It moves to COMMIT when the word's last bit is sampled, back to ARMED when select rises early, and to OFF when the enable bit is cleared.
- COMMIT: storing the word, lasting one cycle. It moves to OFF at the end entry when wrap is off (or when the enable bit has been cleared), otherwise to XFER if select is still low and to ARMED if select is high.

When the end entry completes, the completion flag is set. Without wrap the block then stops itself; with wrap it continues from the start index. The interrupt line follows the flag, gated by an interrupt enable that is sampled when the flag is raised.

Top module: `queued_spi_slave`

## Requirements
- R1: Register map (word registers at CPU addresses):
  - Address 0 is control: [0] enable, [1] wrap, [2] interrupt enable, [3] clock polarity, [4] clock phase, [11:8] word length (0 means 16).
  - Address 1 holds the indices: [3:0] start index, [11:8] end index.
  - Address 2 is status: [0] completion flag, [11:8] index of the last completed entry.
  - Addresses 16 to 31 give entry (address − 16): a write sets its transmit word and a read returns its received word.
  - After reset, every register reads 0, `irq` is low and `miso_oe` is low.
- R2: `miso_oe` is high only while the block is enabled and select is low. Once select is high, `miso_oe` is low within three clocks.
- R3: For a word length N, the block sends bits N−1 down to 0 of the current entry's transmit word, most significant first. A word length field of 0 sends all 16 bits.
- R4: MOSI is sampled on the SCK edge that moves SCK to the level NOT(polarity XOR phase). MISO changes only on the opposite edge. The first bit of a word is on MISO before the word's first SCK edge, in all four modes.
- R5: When N bits have been sampled, the block does four things in order:
  - it stores the word at the current entry, first received bit in bit N−1 and upper bits zero;
  - it copies the index into the status field;
  - it advances the index;
  - it loads the next transmit word.
- R6: Select may stay low across words or rise between them. The queue position carries over a deselect.
- R7: A write to address 1 makes the next select start at the new start index instead of the carried-over position.
- R8: If select rises before N bits, the partial word is dropped: nothing is stored, the completed index is unchanged, and the same entry is sent again from its first bit at the next select.
- R9: Completing the end entry always sets the flag. With wrap off, the block also clears the enable bit and stops, so a later select does not drive MISO.
- R10: With wrap on, the entry after the end entry is the start index. The flag is set at every pass and the enable bit stays set.
- R11: `irq` is the flag ANDed with the interrupt enable as sampled when the flag is set. Clearing the enable afterwards does not drop a pending `irq`. A flag set while the enable is clear leaves `irq` low.
- R12: The flag clears only when the status register is read while the flag is set and then written with bit 0 zero. A write without that earlier read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cpu_wr | input | 1 | register write strobe |
| cpu_rd | input | 1 | register read strobe (read side effects only) |
| cpu_addr | input | 5 | register / queue entry address |
| cpu_wdata | input | 16 | write data |
| cpu_rdata | output | 16 | read data for `cpu_addr` (combinational) |
| irq | output | 1 | completion interrupt request |
| sck | input | 1 | serial clock from master |
| mosi | input | 1 | serial data from master |
| ss_n | input | 1 | active-low slave select |
| miso | output | 1 | serial data to master |
| miso_oe | output | 1 | output enable for `miso` |

## Verification
The hardest state to reach from the ports is a word that the master abandons part way. The index must stay put while the shifter is left holding stale bits. The bench first moves the queue to a new start index, then sends only three clocks of a word and raises select. It then checks that the entry's receive word and the completed index are unchanged, and that the next full word starts again from the most significant transmit bit. A second hard case is an interrupt enable cleared while a request is pending. The bench reaches it by ending a queue with the enable set, clearing the enable over the register bus, and watching `irq` before and after the flag is cleared. Word lengths, data and the four clock modes are drawn at random from a fixed seed, and select is held low for some runs and toggled for others.

// File: rtl/qss_pkg.sv
package qss_pkg;
    localparam int WORD_W = 16;
    localparam int QDEPTH = 16;
    localparam int PTR_W  = $clog2(QDEPTH);
    localparam int CNT_W  = $clog2(WORD_W + 1);
    localparam int ADDR_W = PTR_W + 1;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_QPTR = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_STAT = ADDR_W'(2);

    typedef enum logic [1:0] {
        ST_OFF,
        ST_ARMED,
        ST_XFER,
        ST_COMMIT
    } seq_state_t;

    typedef struct packed {
        logic [3:0] nbits_code;
        logic       cpha;
        logic       cpol;
        logic       irq_en;
        logic       wrap;
        logic       en;
    } ctrl_t;
endpackage

// File: rtl/qss_sync.sv
module qss_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] INIT   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/qss_shifter.sv
module qss_shifter #(
    parameter int  WORD_W = 16,
    localparam int CNT_W  = $clog2(WORD_W + 1),
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              sample_en,
    input  logic              shift_en,
    input  logic              mosi,
    input  logic [CNT_W-1:0]  nbits,
    output logic              miso_bit,
    output logic [WORD_W-1:0] rx_word,
    output logic              done
);
    logic [WORD_W-1:0] tx_sr;
    logic [WORD_W-1:0] rx_sr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  top_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
            rx_sr <= '0;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load)
                tx_sr <= load_word;
            else if (shift_en && cnt != '0)
                tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
            if (clr) begin
                cnt <= '0;
            end else if (sample_en) begin
                rx_sr <= (cnt == '0) ? {{(WORD_W-1){1'b0}}, mosi}
                                     : {rx_sr[WORD_W-2:0], mosi};
                if (cnt + CNT_W'(1) == nbits) begin
                    cnt  <= '0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end

    assign top_idx  = nbits - CNT_W'(1);
    assign miso_bit = tx_sr[top_idx[IDX_W-1:0]];
    assign rx_word  = rx_sr;

    // R5: a word can only complete on a sampling edge
    assert_done_after_sample_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sample_en));
    // R3: the count never exceeds the programmed length while shifting
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !clr && $stable(nbits)) |=> (cnt < nbits));
endmodule

// File: rtl/qss_regs.sv
module qss_regs
    import qss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    input  logic [WORD_W-1:0] q_rdata,
    input  logic [PTR_W-1:0]  cpt,
    input  logic              set_flag,
    input  logic              stop_en,
    output ctrl_t             cfg,
    output logic [PTR_W-1:0]  start_ptr,
    output logic [PTR_W-1:0]  end_ptr,
    output logic              qptr_wr,
    output logic              q_we,
    output logic [PTR_W-1:0]  q_addr,
    output logic [WORD_W-1:0] q_wdata,
    output logic              flag,
    output logic              irq
);
    logic is_q;
    logic stat_wr;
    logic rd_seen;
    logic irq_en_q;
    logic irq_arm;

    assign is_q    = cpu_addr[ADDR_W-1];
    assign qptr_wr = cpu_wr && cpu_addr == ADDR_QPTR;
    assign stat_wr = cpu_wr && cpu_addr == ADDR_STAT;
    assign q_we    = cpu_wr && is_q;
    assign q_addr  = cpu_addr[PTR_W-1:0];
    assign q_wdata = cpu_wdata;

    always_comb begin
        cpu_rdata = '0;
        if (is_q) begin
            cpu_rdata = q_rdata;
        end else begin
            case (cpu_addr)
                ADDR_CTRL: cpu_rdata = WORD_W'({cfg.nbits_code, 3'b000, cfg.cpha,
                                                cfg.cpol, cfg.irq_en, cfg.wrap, cfg.en});
                ADDR_QPTR: cpu_rdata = WORD_W'({end_ptr, 4'b0000, start_ptr});
                ADDR_STAT: cpu_rdata = WORD_W'({cpt, 7'b0000000, flag});
                default:   cpu_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            start_ptr <= '0;
            end_ptr   <= '0;
            flag      <= 1'b0;
            rd_seen   <= 1'b0;
            irq_en_q  <= 1'b0;
            irq_arm   <= 1'b0;
        end else begin
            irq_en_q <= cfg.irq_en;
            if (cpu_wr && cpu_addr == ADDR_CTRL) begin
                cfg.en         <= cpu_wdata[0];
                cfg.wrap       <= cpu_wdata[1];
                cfg.irq_en     <= cpu_wdata[2];
                cfg.cpol       <= cpu_wdata[3];
                cfg.cpha       <= cpu_wdata[4];
                cfg.nbits_code <= cpu_wdata[11:8];
            end
            if (stop_en) cfg.en <= 1'b0;
            if (qptr_wr) begin
                start_ptr <= cpu_wdata[PTR_W-1:0];
                end_ptr   <= cpu_wdata[8 +: PTR_W];
            end
            if (cpu_rd && cpu_addr == ADDR_STAT && flag) rd_seen <= 1'b1;
            if (set_flag) begin
                flag    <= 1'b1;
                irq_arm <= irq_arm | irq_en_q;
            end else if (stat_wr && !cpu_wdata[0] && rd_seen) begin
                flag    <= 1'b0;
                irq_arm <= 1'b0;
                rd_seen <= 1'b0;
            end
        end
    end

    assign irq = flag & irq_arm;

    // R9: the flag only rises because the sequencer reported the end entry
    assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_flag));
    // R12: the flag only falls after a zero write to status
    assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(stat_wr && !cpu_wdata[0]));
    // R11: a pending request is only withdrawn by clearing the flag
    assert_irq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> !flag);
endmodule

// File: rtl/queued_spi_slave.sv
module queued_spi_slave
    import qss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              irq,
    input  logic              sck,
    input  logic              mosi,
    input  logic              ss_n,
    output logic              miso,
    output logic              miso_oe
);
    seq_state_t state, nstate;

    logic sck_s, mosi_s, ss_s, sck_d;
    logic sck_edge, sample_en, shift_en;

    ctrl_t             cfg;
    logic [PTR_W-1:0]  start_ptr, end_ptr, q_addr;
    logic              qptr_wr, q_we, flag;
    logic [WORD_W-1:0] q_wdata, q_rdata;

    logic [WORD_W-1:0] tx_mem [QDEPTH];
    logic [WORD_W-1:0] rx_mem [QDEPTH];
    logic [PTR_W-1:0]  wptr, cpt, nxt_ptr, sel_ptr;
    logic              pend, at_end;

    logic [CNT_W-1:0]  nbits;
    logic [WORD_W-1:0] mask;
    logic              ld, shf_clr, rx_we, set_flag, stop_en;
    logic [WORD_W-1:0] ld_word, rx_word;
    logic              miso_bit, done;

    qss_sync #(.W(3), .STAGES(2), .INIT(3'b100)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({ss_n, mosi, sck}),
        .q    ({ss_s, mosi_s, sck_s})
    );

    qss_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_wr   (cpu_wr),
        .cpu_rd   (cpu_rd),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .q_rdata  (q_rdata),
        .cpt      (cpt),
        .set_flag (set_flag),
        .stop_en  (stop_en),
        .cfg      (cfg),
        .start_ptr(start_ptr),
        .end_ptr  (end_ptr),
        .qptr_wr  (qptr_wr),
        .q_we     (q_we),
        .q_addr   (q_addr),
        .q_wdata  (q_wdata),
        .flag     (flag),
        .irq      (irq)
    );

    qss_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (shf_clr),
        .load     (ld),
        .load_word(ld_word),
        .sample_en(sample_en),
        .shift_en (shift_en),
        .mosi     (mosi_s),
        .nbits    (nbits),
        .miso_bit (miso_bit),
        .rx_word  (rx_word),
        .done     (done)
    );

    assign nbits     = {(cfg.nbits_code == 4'd0), cfg.nbits_code};
    assign mask      = (nbits == CNT_W'(WORD_W)) ? '1
                                                 : ((WORD_W'(1) << nbits) - WORD_W'(1));
    assign sck_edge  = sck_s != sck_d;
    assign sample_en = sck_edge && state == ST_XFER && (sck_s == !(cfg.cpol ^ cfg.cpha));
    assign shift_en  = sck_edge && state == ST_XFER && (sck_s == (cfg.cpol ^ cfg.cpha));
    assign at_end    = wptr == end_ptr;
    assign nxt_ptr   = (at_end && cfg.wrap) ? start_ptr : wptr + PTR_W'(1);
    assign sel_ptr   = pend ? start_ptr : wptr;
    assign q_rdata   = rx_mem[q_addr];
    assign miso      = miso_bit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nstate;
    end

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_OFF:    if (cfg.en) nstate = ST_ARMED;
            ST_ARMED:  if (!cfg.en) nstate = ST_OFF;
                       else if (!ss_s) nstate = ST_XFER;
            ST_XFER:   if (!cfg.en) nstate = ST_OFF;
                       else if (done) nstate = ST_COMMIT;
                       else if (ss_s) nstate = ST_ARMED;
            ST_COMMIT: if ((at_end && !cfg.wrap) || !cfg.en) nstate = ST_OFF;
                       else if (ss_s) nstate = ST_ARMED;
                       else nstate = ST_XFER;
        endcase
    end

    // state outputs
    always_comb begin
        ld       = 1'b0;
        ld_word  = tx_mem[sel_ptr];
        shf_clr  = 1'b1;
        rx_we    = 1'b0;
        set_flag = 1'b0;
        stop_en  = 1'b0;
        miso_oe  = 1'b0;
        unique case (state)
            ST_OFF:    ;
            ST_ARMED:  ld = cfg.en && !ss_s;
            ST_XFER: begin
                shf_clr = 1'b0;
                miso_oe = 1'b1;
            end
            ST_COMMIT: begin
                shf_clr  = 1'b0;
                miso_oe  = 1'b1;
                rx_we    = 1'b1;
                ld       = 1'b1;
                ld_word  = tx_mem[nxt_ptr];
                set_flag = at_end;
                stop_en  = at_end && !cfg.wrap;
            end
        endcase
    end

    // queue position and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            wptr  <= '0;
            cpt   <= '0;
            pend  <= 1'b1;
            for (int i = 0; i < QDEPTH; i++) begin
                tx_mem[i] <= '0;
                rx_mem[i] <= '0;
            end
        end else begin
            sck_d <= sck_s;
            if (state == ST_ARMED && ld) begin
                wptr <= sel_ptr;
                pend <= 1'b0;
            end
            if (qptr_wr) pend <= 1'b1;
            if (rx_we) begin
                rx_mem[wptr] <= rx_word & mask;
                cpt          <= wptr;
                wptr         <= nxt_ptr;
            end
            if (q_we) tx_mem[q_addr] <= q_wdata;
        end
    end

    // R2: a deselected slave releases MISO by the next cycle
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> !miso_oe);
    // R5: the completed index is the entry that was just stored
    assert_cpt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT) |=> (cpt == $past(wptr)));
    // R9: end entry without wrap stops the block and drops enable
    assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && at_end && !cfg.wrap) |=> (state == ST_OFF && !cfg.en));
    // R10: wrap returns to the start index
    assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMMIT && at_end && cfg.wrap) |=> (wptr == $past(start_ptr)));
    // R8: an aborted word leaves the position untouched
    assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && nstate == ST_ARMED) |=> $stable(wptr));
endmodule

// File: tb/queued_spi_slave_tb.sv
module queued_spi_slave_tb;
    localparam int CLK_P = 10;
    localparam int HALF  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [4:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq, miso, miso_oe;
    logic        sck = 1'b0, mosi = 1'b0, ss_n = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] txq [16];
    logic [15:0] rxq [16];

    queued_spi_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .ss_n(ss_n),
        .miso(miso), .miso_oe(miso_oe)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] mask_of(input int n);
        return (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
    endfunction

    function automatic int next_ptr(input int p, input int st, input int en, input bit wrap);
        if (p == en && wrap) return st;
        return (p + 1) % 16;
    endfunction

    function automatic logic [15:0] mk_ctrl(input bit en, input bit wrap, input bit ie,
                                            input bit cpol, input bit cpha, input int n);
        logic [3:0] code;
        code = (n == 16) ? 4'd0 : 4'(n);
        return {4'b0, code, 3'b0, cpha, cpol, ie, wrap, en};
    endfunction

    function automatic logic [15:0] stat_of(input int cpt, input bit f);
        return {4'b0, 4'(cpt), 7'b0, f};
    endfunction

    task automatic wait_clk(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic select();
        ss_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic deselect();
        ss_n = 1'b1; wait_clk(HALF);
    endtask

    task automatic spi_word(input logic [15:0] mo, input int n, input bit cpol,
                            input bit cpha, output logic [15:0] mi);
        mi = '0;
        for (int i = n - 1; i >= 0; i--) begin
            if (!cpha) begin
                mosi = mo[i]; wait_clk(HALF);
                mi[i] = miso; sck = ~cpol; wait_clk(HALF);
                sck = cpol;
            end else begin
                sck = ~cpol; mosi = mo[i]; wait_clk(HALF);
                mi[i] = miso; sck = cpol; wait_clk(HALF);
            end
        end
        wait_clk(8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rd, mo, mi;
        int p, n;
        bit cpol, cpha;
        void'($urandom(32'd1357));
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);

        // R1 reset state
        check("R1 irq after reset", irq, 0);
        check("R1 miso_oe after reset", miso_oe, 0);
        cpu_read(5'd0, rd); check("R1 ctrl reset", rd, 16'h0);
        cpu_read(5'd2, rd); check("R1 status reset", rd, 16'h0);

        for (int i = 0; i < 16; i++) begin
            txq[i] = 16'($urandom);
            rxq[i] = 16'h0;
            cpu_write(5'(16 + i), txq[i]);
        end

        // 16-bit words, mode 0, select held low, no wrap: entries 2..5
        cpu_write(5'd1, {4'b0, 4'd5, 4'b0, 4'd2});
        cpu_write(5'd0, mk_ctrl(1, 0, 1, 0, 0, 16));
        wait_clk(4);
        select();
        check("R2 miso_oe while selected", miso_oe, 1);
        p = 2;
        for (int k = 0; k < 4; k++) begin
            mo = 16'($urandom);
            spi_word(mo, 16, 0, 0, mi);
            check("R3 16-bit msb-first word mode 0", mi, txq[p]);
            rxq[p] = mo;
            p = next_ptr(p, 2, 5, 0);
        end
        deselect();
        check("R2 miso_oe released on deselect", miso_oe, 0);
        check("R11 irq raised at end", irq, 1);
        cpu_write(5'd2, 16'h0);
        wait_clk(1);
        check("R12 write without read keeps flag", irq, 1);
        cpu_read(5'd2, rd); check("R9 flag and completed index", rd, stat_of(5, 1));
        cpu_read(5'd0, rd); check("R9 enable cleared at end", rd, mk_ctrl(0, 0, 1, 0, 0, 16));
        for (int i = 2; i <= 5; i++) begin
            cpu_read(5'(16 + i), rd); check("R5 received word stored", rd, rxq[i]);
        end
        select();
        check("R9 stopped block leaves miso off", miso_oe, 0);
        deselect();
        cpu_read(5'd2, rd);
        cpu_write(5'd2, 16'h0);
        wait_clk(1);
        check("R12 read then zero write clears irq", irq, 0);
        cpu_read(5'd2, rd); check("R12 flag cleared", rd, stat_of(5, 0));

        // three modes, random length, wrap over entries 8..9
        for (int m = 1; m < 4; m++) begin
            cpol = m[1]; cpha = m[0];
            n = 1 + int'($urandom % 16);
            cpu_write(5'd0, mk_ctrl(0, 1, 0, cpol, cpha, n));
            sck = cpol;
            wait_clk(6);
            cpu_write(5'd1, {4'b0, 4'd9, 4'b0, 4'd8});
            cpu_write(5'd0, mk_ctrl(1, 1, 0, cpol, cpha, n));
            wait_clk(4);
            p = 8;
            if (m == 2) select();
            for (int k = 0; k < 5; k++) begin
                if (m != 2) select();
                mo = 16'($urandom) & mask_of(n);
                spi_word(mo, n, cpol, cpha, mi);
                check((m == 2) ? "R6 held select word" : "R6 toggled select word",
                      mi, txq[p] & mask_of(n));
                check("R4 mode edges give transmit bits", mi, txq[p] & mask_of(n));
                rxq[p] = mo;
                p = next_ptr(p, 8, 9, 1);
                if (m != 2) deselect();
            end
            if (m == 2) deselect();
            cpu_read(5'd2, rd); check("R10 flag set with wrap", rd, stat_of(8, 1));
            cpu_read(5'd0, rd); check("R10 enable kept with wrap", rd[0], 1);
            check("R11 no irq when enable clear", irq, 0);
            cpu_read(5'd24, rd); check("R5 masked word entry 8", rd, rxq[8]);
            cpu_read(5'd25, rd); check("R5 masked word entry 9", rd, rxq[9]);
            cpu_write(5'd2, 16'h0);
        end

        // new start index and aborted word
        cpu_write(5'd0, mk_ctrl(0, 0, 1, 0, 0, 16));
        sck = 1'b0;
        wait_clk(6);
        cpu_write(5'd1, {4'b0, 4'd14, 4'b0, 4'd12});
        cpu_write(5'd0, mk_ctrl(1, 0, 1, 0, 0, 16));
        wait_clk(4);
        select();
        spi_word(16'hA000, 3, 0, 0, mi);
        check("R7 start index used on select", mi, {13'b0, txq[12][15:13]});
        deselect();
        cpu_read(5'd28, rd); check("R8 partial word not stored", rd, rxq[12]);
        cpu_read(5'd2, rd); check("R8 completed index unchanged", rd, stat_of(8, 0));
        select();
        for (int k = 0; k < 3; k++) begin
            mo = 16'($urandom);
            spi_word(mo, 16, 0, 0, mi);
            check("R8 entry resent from first bit", mi, txq[12 + k]);
            rxq[12 + k] = mo;
        end
        deselect();
        cpu_read(5'd28, rd); check("R5 word after abort stored", rd, rxq[12]);
        check("R11 irq pending", irq, 1);
        cpu_write(5'd0, 16'h0);
        wait_clk(3);
        check("R11 clearing enable keeps pending irq", irq, 1);
        cpu_read(5'd2, rd); check("R9 end index recorded", rd, stat_of(14, 1));
        cpu_write(5'd2, 16'h0);
        wait_clk(1);
        check("R12 clear drops irq", irq, 0);

        // single-entry queue with interrupt enable off
        cpu_write(5'd1, {4'b0, 4'd3, 4'b0, 4'd3});
        cpu_write(5'd0, mk_ctrl(1, 0, 0, 0, 0, 16));
        wait_clk(4);
        select();
        mo = 16'($urandom);
        spi_word(mo, 16, 0, 0, mi);
        check("R3 single entry word", mi, txq[3]);
        deselect();
        check("R11 later flag without enable keeps irq low", irq, 0);
        cpu_read(5'd2, rd); check("R9 single-entry end", rd, stat_of(3, 1));
        cpu_read(5'd19, rd); check("R5 single entry stored", rd, mo);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule